// File: doc/BRIEF.md
# Banked Floating-Point Register File

This block holds the single-precision register storage of a floating-point unit: 64 words of 32 bits behind several addressing views. A word port reaches the storage directly, through the active bank, through the opposite bank, as the base of a 4-word vector, or as the base of a 16-word matrix. A separate pair port moves 64-bit doubles built from two neighbouring words. The active bank is chosen by a mode bit in a 32-bit status register. The block also owns that status register and a 32-bit floating-point status word.

A combined control view merges the status word with three mode bits from the status register: precision, size and bank. Writing the combined view updates both registers at once. Every write lands on the rising clock edge. Every read is combinational and follows the state present in that cycle. A change of the bank bit therefore moves the banked views from the next cycle on.

Top module: `banked_fpr_file`

## Requirements
- R1: Reset (active-low `rst_n`) clears all 64 entries, the status register and the floating-point status word, so every read port returns zero.
- R2: Word view code 0 (and the unused codes 5 to 7) addresses entry `idx` directly. A write is visible on the read port only after the next rising edge.
- R3: The bank bit is status bit 14. Word view code 1 (current bank) addresses entry 16*bank + idx[3:0]. Word view code 2 (opposite bank) addresses entry 16*(1-bank) + idx[3:0].
- R4: Word view code 3 (vector) addresses entry 4*idx[3:0]. Word view code 4 (matrix) addresses entry 16*idx[1:0]. Higher index bits are ignored in both.
- R5: A pair read at base b returns entry b in bits [63:32] and entry b+1 in bits [31:0]. A pair write stores the two halves the same way.
- R6: Pair view codes are 0 direct, 1 current bank and 2 opposite bank; code 3 acts as direct. The bank offset is applied before the pair is formed. The second entry is (b+1) mod 64, so base 63 pairs with entry 0.
- R7: The combined control read is the status word ORed with status bit 12 (precision) at bit 19, status bit 13 (size) at bit 20 and status bit 14 (bank) at bit 21.
- R8: A combined control write stores all 32 bits into the status word and copies its bits 19, 20 and 21 into status bits 12, 13 and 14. All other status bits keep their value.
- R9: In one cycle, a pair write overrides a word write on any entry both touch. A combined control write overrides a status write on status bits 12 to 14, and the status write supplies the remaining status bits.
- R10: A status register write stores all 32 bits, which read back unchanged on `stat_rd_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sgl_rd_view | input | 3 | Word read view code |
| sgl_rd_idx | input | 6 | Word read index |
| sgl_rd_data | output | 32 | Word read data |
| sgl_wr_en | input | 1 | Word write enable |
| sgl_wr_view | input | 3 | Word write view code |
| sgl_wr_idx | input | 6 | Word write index |
| sgl_wr_data | input | 32 | Word write data |
| dbl_rd_view | input | 2 | Pair read view code |
| dbl_rd_idx | input | 6 | Pair read base index |
| dbl_rd_data | output | 64 | Pair read data |
| dbl_wr_en | input | 1 | Pair write enable |
| dbl_wr_view | input | 2 | Pair write view code |
| dbl_wr_idx | input | 6 | Pair write base index |
| dbl_wr_data | input | 64 | Pair write data |
| stat_wr_en | input | 1 | Status register write enable |
| stat_wr_data | input | 32 | Status register write data |
| stat_rd_data | output | 32 | Status register contents |
| fpc_wr_en | input | 1 | Combined control write enable |
| fpc_wr_data | input | 32 | Combined control write data |
| fpc_rd_data | output | 32 | Combined control read value |
| fsw_rd_data | output | 32 | Raw floating-point status word |

## Verification
The hardest case to reach is a pair access through a banked view at the last slot of a bank, where the second word crosses into the next region. The direct view at entry 63 behaves the same way and wraps to entry 0. To get there, the stimulus first moves the bank bit with a combined control write. It then issues pair writes at index 15 through the current and the opposite bank, and at base 63 directly. Each affected entry is read back one word at a time. A second hard case is the same-cycle collision of status and combined control writes, and of word and pair writes. The bench issues those together in one clock and checks which value wins for each bit and each entry.

// File: rtl/fprf_pkg.sv
package fprf_pkg;

    // word-port view codes
    localparam logic [2:0] VW_DIRECT = 3'd0;
    localparam logic [2:0] VW_CUR    = 3'd1;
    localparam logic [2:0] VW_OPP    = 3'd2;
    localparam logic [2:0] VW_VEC    = 3'd3;
    localparam logic [2:0] VW_MTX    = 3'd4;

    // pair-port view codes
    localparam logic [1:0] PV_DIRECT = 2'd0;
    localparam logic [1:0] PV_CUR    = 2'd1;
    localparam logic [1:0] PV_OPP    = 2'd2;

    // mode bits inside the status register
    localparam int unsigned ST_PREC_BIT = 12;
    localparam int unsigned ST_SIZE_BIT = 13;
    localparam int unsigned ST_BANK_BIT = 14;

    // the same bits as they appear in the combined control view
    localparam int unsigned CC_PREC_BIT = 19;
    localparam int unsigned CC_SIZE_BIT = 20;
    localparam int unsigned CC_BANK_BIT = 21;

    typedef struct packed {
        logic [31:0] stat;
        logic [31:0] fsw;
    } ctrl_regs_t;

endpackage

// File: rtl/fprf_addr_map.sv
module fprf_addr_map #(
    parameter int unsigned N_ENTRIES = 64,
    parameter int unsigned BANK_SIZE = 16,
    parameter int unsigned VEC_LEN   = 4,
    parameter int unsigned MTX_LEN   = 16,
    localparam int unsigned AW       = $clog2(N_ENTRIES)
) (
    input  logic [2:0]    view,
    input  logic [AW-1:0] idx,
    input  logic          bank,
    output logic [AW-1:0] addr
);
    import fprf_pkg::*;

    localparam int unsigned BW  = $clog2(BANK_SIZE);
    localparam int unsigned VSH = $clog2(VEC_LEN);
    localparam int unsigned VW  = AW - VSH;
    localparam int unsigned MSH = $clog2(MTX_LEN);
    localparam int unsigned MW  = AW - MSH;

    logic [AW-1:0] cur_addr;
    logic [AW-1:0] opp_addr;
    logic [AW-1:0] vec_addr;
    logic [AW-1:0] mtx_addr;

    assign cur_addr = AW'({bank,  idx[BW-1:0]});
    assign opp_addr = AW'({~bank, idx[BW-1:0]});
    assign vec_addr = {idx[VW-1:0], {VSH{1'b0}}};
    assign mtx_addr = {idx[MW-1:0], {MSH{1'b0}}};

    always_comb begin
        case (view)
            VW_CUR:  addr = cur_addr;
            VW_OPP:  addr = opp_addr;
            VW_VEC:  addr = vec_addr;
            VW_MTX:  addr = mtx_addr;
            default: addr = idx;
        endcase
    end

endmodule

// File: rtl/fprf_store.sv
module fprf_store #(
    parameter int unsigned N_ENTRIES = 64,
    parameter int unsigned WORD_W    = 32,
    parameter int unsigned N_RD      = 3,
    localparam int unsigned AW       = $clog2(N_ENTRIES)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                w_en,
    input  logic [AW-1:0]       w_addr,
    input  logic [WORD_W-1:0]   w_data,
    input  logic                p_en,
    input  logic [AW-1:0]       p_addr,
    input  logic [2*WORD_W-1:0] p_data,
    input  logic [AW-1:0]       rd_addr [N_RD],
    output logic [WORD_W-1:0]   rd_data [N_RD]
);
    logic [WORD_W-1:0] mem_d [N_ENTRIES];
    logic [WORD_W-1:0] mem_q [N_ENTRIES];
    logic [AW-1:0]     p_addr_nxt;

    // second word of a pair wraps naturally in AW bits
    assign p_addr_nxt = p_addr + AW'(1);

    always_comb begin
        for (int i = 0; i < N_ENTRIES; i++) begin
            mem_d[i] = mem_q[i];
        end
        if (w_en) begin
            mem_d[w_addr] = w_data;
        end
        // pair write applied last so it wins on overlap
        if (p_en) begin
            mem_d[p_addr]     = p_data[2*WORD_W-1:WORD_W];
            mem_d[p_addr_nxt] = p_data[WORD_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < N_ENTRIES; i++) begin
            if (!rst_n) begin
                mem_q[i] <= '0;
            end else begin
                mem_q[i] <= mem_d[i];
            end
        end
    end

    for (genvar g = 0; g < N_RD; g++) begin : g_rd
        assign rd_data[g] = mem_q[rd_addr[g]];
    end

endmodule

// File: rtl/fprf_ctrl.sv
module fprf_ctrl (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        st_we,
    input  logic [31:0] st_wdata,
    input  logic        cc_we,
    input  logic [31:0] cc_wdata,
    output logic [31:0] st_q,
    output logic [31:0] fsw_q,
    output logic [31:0] cc_rdata,
    output logic        bank
);
    import fprf_pkg::*;

    ctrl_regs_t regs_d;
    ctrl_regs_t regs_q;

    always_comb begin
        regs_d = regs_q;
        if (st_we) begin
            regs_d.stat = st_wdata;
        end
        if (cc_we) begin
            regs_d.fsw                  = cc_wdata;
            regs_d.stat[ST_PREC_BIT]    = cc_wdata[CC_PREC_BIT];
            regs_d.stat[ST_SIZE_BIT]    = cc_wdata[CC_SIZE_BIT];
            regs_d.stat[ST_BANK_BIT]    = cc_wdata[CC_BANK_BIT];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    logic [31:0] mode_lift;

    always_comb begin
        mode_lift              = '0;
        mode_lift[CC_PREC_BIT] = regs_q.stat[ST_PREC_BIT];
        mode_lift[CC_SIZE_BIT] = regs_q.stat[ST_SIZE_BIT];
        mode_lift[CC_BANK_BIT] = regs_q.stat[ST_BANK_BIT];
    end

    assign cc_rdata = regs_q.fsw | mode_lift;
    assign st_q     = regs_q.stat;
    assign fsw_q    = regs_q.fsw;
    assign bank     = regs_q.stat[ST_BANK_BIT];

endmodule

// File: rtl/banked_fpr_file.sv
module banked_fpr_file #(
    parameter int unsigned N_ENTRIES = 64,
    parameter int unsigned WORD_W    = 32,
    parameter int unsigned BANK_SIZE = 16,
    parameter int unsigned VEC_LEN   = 4,
    parameter int unsigned MTX_LEN   = 16,
    localparam int unsigned AW       = $clog2(N_ENTRIES),
    localparam int unsigned DW       = 2 * WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        sgl_rd_view,
    input  logic [AW-1:0]     sgl_rd_idx,
    output logic [WORD_W-1:0] sgl_rd_data,
    input  logic              sgl_wr_en,
    input  logic [2:0]        sgl_wr_view,
    input  logic [AW-1:0]     sgl_wr_idx,
    input  logic [WORD_W-1:0] sgl_wr_data,
    input  logic [1:0]        dbl_rd_view,
    input  logic [AW-1:0]     dbl_rd_idx,
    output logic [DW-1:0]     dbl_rd_data,
    input  logic              dbl_wr_en,
    input  logic [1:0]        dbl_wr_view,
    input  logic [AW-1:0]     dbl_wr_idx,
    input  logic [DW-1:0]     dbl_wr_data,
    input  logic              stat_wr_en,
    input  logic [31:0]       stat_wr_data,
    output logic [31:0]       stat_rd_data,
    input  logic              fpc_wr_en,
    input  logic [31:0]       fpc_wr_data,
    output logic [31:0]       fpc_rd_data,
    output logic [31:0]       fsw_rd_data
);
    import fprf_pkg::*;

    localparam int unsigned N_MAP = 4;  // word rd, word wr, pair rd, pair wr
    localparam int unsigned N_RD  = 3;  // word, pair high, pair low

    logic              bank;
    logic [2:0]        map_view [N_MAP];
    logic [AW-1:0]     map_idx  [N_MAP];
    logic [AW-1:0]     map_addr [N_MAP];
    logic [AW-1:0]     rd_addr  [N_RD];
    logic [WORD_W-1:0] rd_data  [N_RD];

    // pair codes fold onto word codes; code 3 becomes direct
    function automatic logic [2:0] pair_to_word(input logic [1:0] pv);
        case (pv)
            PV_CUR:  return VW_CUR;
            PV_OPP:  return VW_OPP;
            default: return VW_DIRECT;
        endcase
    endfunction

    assign map_view[0] = sgl_rd_view;
    assign map_idx[0]  = sgl_rd_idx;
    assign map_view[1] = sgl_wr_view;
    assign map_idx[1]  = sgl_wr_idx;
    assign map_view[2] = pair_to_word(dbl_rd_view);
    assign map_idx[2]  = dbl_rd_idx;
    assign map_view[3] = pair_to_word(dbl_wr_view);
    assign map_idx[3]  = dbl_wr_idx;

    for (genvar g = 0; g < N_MAP; g++) begin : g_map
        fprf_addr_map #(
            .N_ENTRIES (N_ENTRIES),
            .BANK_SIZE (BANK_SIZE),
            .VEC_LEN   (VEC_LEN),
            .MTX_LEN   (MTX_LEN)
        ) u_map (
            .view (map_view[g]),
            .idx  (map_idx[g]),
            .bank (bank),
            .addr (map_addr[g])
        );
    end

    assign rd_addr[0] = map_addr[0];
    assign rd_addr[1] = map_addr[2];
    assign rd_addr[2] = map_addr[2] + AW'(1);

    fprf_store #(
        .N_ENTRIES (N_ENTRIES),
        .WORD_W    (WORD_W),
        .N_RD      (N_RD)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .w_en    (sgl_wr_en),
        .w_addr  (map_addr[1]),
        .w_data  (sgl_wr_data),
        .p_en    (dbl_wr_en),
        .p_addr  (map_addr[3]),
        .p_data  (dbl_wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    fprf_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .st_we    (stat_wr_en),
        .st_wdata (stat_wr_data),
        .cc_we    (fpc_wr_en),
        .cc_wdata (fpc_wr_data),
        .st_q     (stat_rd_data),
        .fsw_q    (fsw_rd_data),
        .cc_rdata (fpc_rd_data),
        .bank     (bank)
    );

    assign sgl_rd_data = rd_data[0];
    assign dbl_rd_data = {rd_data[1], rd_data[2]};

endmodule

// File: rtl/fprf_checker.sv
module fprf_checker #(
    parameter int unsigned AW     = 6,
    parameter int unsigned WORD_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [2:0]        sgl_rd_view,
    input logic [AW-1:0]     sgl_rd_idx,
    input logic [WORD_W-1:0] sgl_rd_data,
    input logic              sgl_wr_en,
    input logic              dbl_wr_en,
    input logic              stat_wr_en,
    input logic [31:0]       stat_wr_data,
    input logic [31:0]       stat_rd_data,
    input logic              fpc_wr_en,
    input logic [31:0]       fpc_wr_data,
    input logic [31:0]       fpc_rd_data,
    input logic [31:0]       fsw_rd_data
);

    // R1: one cycle in reset leaves control state at zero
    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (stat_rd_data == 32'd0 && fsw_rd_data == 32'd0 && fpc_rd_data == 32'd0));

    // R2: without any write and with unchanged word read inputs, the word read holds
    a_r2_read_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!sgl_wr_en && !dbl_wr_en && !stat_wr_en && !fpc_wr_en)
        |=> ((sgl_rd_view == $past(sgl_rd_view) && sgl_rd_idx == $past(sgl_rd_idx))
             ? (sgl_rd_data == $past(sgl_rd_data)) : 1'b1));

    // R10: a lone status write reads back whole
    a_r10_status_write: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_wr_en && !fpc_wr_en) |=> (stat_rd_data == $past(stat_wr_data)));

    // R8: combined write fills the status word
    a_r8_fsw_store: assert property (@(posedge clk) disable iff (!rst_n)
        fpc_wr_en |=> (fsw_rd_data == $past(fpc_wr_data)));

    // R8: combined write copies its three mode bits into the status register
    a_r8_mode_copy: assert property (@(posedge clk) disable iff (!rst_n)
        fpc_wr_en |=> (stat_rd_data[14:12] == $past(fpc_wr_data[21:19])));

    // R8: a lone combined write keeps the other status bits
    a_r8_other_bits_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (fpc_wr_en && !stat_wr_en)
        |=> (stat_rd_data[31:15] == $past(stat_rd_data[31:15])
             && stat_rd_data[11:0] == $past(stat_rd_data[11:0])));

    // R9: on collision the status write supplies the bits outside 12..14
    a_r9_collision_split: assert property (@(posedge clk) disable iff (!rst_n)
        (fpc_wr_en && stat_wr_en)
        |=> (stat_rd_data[31:15] == $past(stat_wr_data[31:15])
             && stat_rd_data[11:0] == $past(stat_wr_data[11:0])));

    // R7: the combined view shows the status mode bits in its upper mode field
    a_r7_mode_visible: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd_data[14:12] & ~fpc_rd_data[21:19]) == 3'b000);

endmodule

bind banked_fpr_file fprf_checker #(.AW(AW), .WORD_W(WORD_W)) u_fprf_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .sgl_rd_view  (sgl_rd_view),
    .sgl_rd_idx   (sgl_rd_idx),
    .sgl_rd_data  (sgl_rd_data),
    .sgl_wr_en    (sgl_wr_en),
    .dbl_wr_en    (dbl_wr_en),
    .stat_wr_en   (stat_wr_en),
    .stat_wr_data (stat_wr_data),
    .stat_rd_data (stat_rd_data),
    .fpc_wr_en    (fpc_wr_en),
    .fpc_wr_data  (fpc_wr_data),
    .fpc_rd_data  (fpc_rd_data),
    .fsw_rd_data  (fsw_rd_data)
);

// File: tb/banked_fpr_file_test.sv
module banked_fpr_file_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [2:0]  sgl_rd_view, sgl_wr_view;
    logic [5:0]  sgl_rd_idx, sgl_wr_idx, dbl_rd_idx, dbl_wr_idx;
    logic [31:0] sgl_rd_data, sgl_wr_data;
    logic        sgl_wr_en, dbl_wr_en, stat_wr_en, fpc_wr_en;
    logic [1:0]  dbl_rd_view, dbl_wr_view;
    logic [63:0] dbl_rd_data, dbl_wr_data;
    logic [31:0] stat_wr_data, stat_rd_data, fpc_wr_data, fpc_rd_data, fsw_rd_data;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    // expected state, kept from the requirements
    logic [31:0] m_mem [64];
    logic [31:0] m_st;
    logic [31:0] m_fsw;

    always #10 clk = ~clk;  // 50 MHz

    banked_fpr_file uut (
        .clk(clk), .rst_n(rst_n),
        .sgl_rd_view(sgl_rd_view), .sgl_rd_idx(sgl_rd_idx), .sgl_rd_data(sgl_rd_data),
        .sgl_wr_en(sgl_wr_en), .sgl_wr_view(sgl_wr_view), .sgl_wr_idx(sgl_wr_idx),
        .sgl_wr_data(sgl_wr_data),
        .dbl_rd_view(dbl_rd_view), .dbl_rd_idx(dbl_rd_idx), .dbl_rd_data(dbl_rd_data),
        .dbl_wr_en(dbl_wr_en), .dbl_wr_view(dbl_wr_view), .dbl_wr_idx(dbl_wr_idx),
        .dbl_wr_data(dbl_wr_data),
        .stat_wr_en(stat_wr_en), .stat_wr_data(stat_wr_data), .stat_rd_data(stat_rd_data),
        .fpc_wr_en(fpc_wr_en), .fpc_wr_data(fpc_wr_data), .fpc_rd_data(fpc_rd_data),
        .fsw_rd_data(fsw_rd_data)
    );

    // R3 and R4 word addressing: 1 current, 2 opposite, 3 vector, 4 matrix, else direct
    function automatic logic [5:0] exp_addr(input logic [2:0] v, input logic [5:0] i);
        logic b;
        b = m_st[14];
        case (v)
            3'd1:    return {1'b0, b, i[3:0]};
            3'd2:    return {1'b0, ~b, i[3:0]};
            3'd3:    return {i[3:0], 2'b00};
            3'd4:    return {i[1:0], 4'b0000};
            default: return i;
        endcase
    endfunction

    // R6 pair codes: 1 current, 2 opposite, 0 and 3 direct
    function automatic logic [2:0] pair_view(input logic [1:0] v);
        return (v == 2'd1) ? 3'd1 : (v == 2'd2) ? 3'd2 : 3'd0;
    endfunction

    function automatic logic [31:0] exp_fpc();
        return m_fsw | ({31'd0, m_st[12]} << 19) | ({31'd0, m_st[13]} << 20)
                     | ({31'd0, m_st[14]} << 21);
    endfunction

    task automatic check32(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic check64(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        sgl_wr_en = 0; dbl_wr_en = 0; stat_wr_en = 0; fpc_wr_en = 0;
        sgl_wr_view = 0; sgl_wr_idx = 0; sgl_wr_data = 0;
        dbl_wr_view = 0; dbl_wr_idx = 0; dbl_wr_data = 0;
        stat_wr_data = 0; fpc_wr_data = 0;
    endtask

    // called at a falling edge with write inputs set; one rising edge commits them
    task automatic commit();
        logic [5:0] wa, pa;
        logic [31:0] st_n;
        wa = exp_addr(sgl_wr_view, sgl_wr_idx);
        pa = exp_addr(pair_view(dbl_wr_view), dbl_wr_idx);
        st_n = m_st;
        @(posedge clk);
        if (sgl_wr_en) m_mem[wa] = sgl_wr_data;
        if (dbl_wr_en) begin
            m_mem[pa]        = dbl_wr_data[63:32];
            m_mem[pa + 6'd1] = dbl_wr_data[31:0];
        end
        if (stat_wr_en) st_n = stat_wr_data;
        if (fpc_wr_en) begin
            m_fsw = fpc_wr_data;
            st_n[14:12] = fpc_wr_data[21:19];
        end
        m_st = st_n;
        @(negedge clk);
        idle_inputs();
    endtask

    task automatic read_word(input logic [2:0] v, input logic [5:0] i, input string req);
        sgl_rd_view = v; sgl_rd_idx = i;
        #1;
        check32(req, sgl_rd_data, m_mem[exp_addr(v, i)]);
    endtask

    task automatic read_direct(input logic [5:0] i, input logic [31:0] exp, input string req);
        sgl_rd_view = 3'd0; sgl_rd_idx = i;
        #1;
        check32(req, sgl_rd_data, exp);
    endtask

    task automatic write_word(input logic [2:0] v, input logic [5:0] i, input logic [31:0] d);
        sgl_wr_en = 1; sgl_wr_view = v; sgl_wr_idx = i; sgl_wr_data = d;
        commit();
    endtask

    task automatic write_pair(input logic [1:0] v, input logic [5:0] i, input logic [63:0] d);
        dbl_wr_en = 1; dbl_wr_view = v; dbl_wr_idx = i; dbl_wr_data = d;
        commit();
    endtask

    task automatic write_fpc(input logic [31:0] d);
        fpc_wr_en = 1; fpc_wr_data = d;
        commit();
    endtask

    task automatic write_stat(input logic [31:0] d);
        stat_wr_en = 1; stat_wr_data = d;
        commit();
    endtask

    task automatic t_reset();
        for (int i = 0; i < 64; i++) read_direct(6'(i), 32'd0, "R1 entry");
        check32("R1 status", stat_rd_data, 32'd0);
        check32("R1 fsw", fsw_rd_data, 32'd0);
        check32("R1 combined", fpc_rd_data, 32'd0);
        dbl_rd_view = 0; dbl_rd_idx = 6'd7; #1;
        check64("R1 pair", dbl_rd_data, 64'd0);
    endtask

    task automatic t_direct();
        sgl_wr_en = 1; sgl_wr_view = 3'd0; sgl_wr_idx = 6'd5; sgl_wr_data = 32'hA5A5_0005;
        sgl_rd_view = 3'd0; sgl_rd_idx = 6'd5; #1;
        check32("R2 before edge", sgl_rd_data, 32'd0);
        commit();
        read_direct(6'd5, 32'hA5A5_0005, "R2 after edge");
        write_word(3'd0, 6'd40, 32'h1234_5678);
        write_word(3'd6, 6'd41, 32'h0BAD_F00D);  // unused code acts as direct
        read_direct(6'd40, 32'h1234_5678, "R2 direct 40");
        read_direct(6'd41, 32'h0BAD_F00D, "R2 unused view code");
    endtask

    task automatic t_bank();
        write_word(3'd1, 6'd3, 32'hC0C0_0003);           // bank 0
        read_direct(6'd3, 32'hC0C0_0003, "R3 current bank0 -> 3");
        write_word(3'd2, 6'd3, 32'hE0E0_0013);
        read_direct(6'd19, 32'hE0E0_0013, "R3 opposite bank0 -> 19");
        write_stat(32'h0000_4000);                        // bank 1
        check32("R10 status readback", stat_rd_data, 32'h0000_4000);
        read_word(3'd1, 6'd3, "R3 current bank1 reads 19");
        read_word(3'd2, 6'd3, "R3 opposite bank1 reads 3");
        write_word(3'd1, 6'd35, 32'h7777_0023);           // idx[5:4] ignored
        read_direct(6'd19, 32'h7777_0023, "R3 current bank1 idx35 -> 19");
    endtask

    task automatic t_vecmtx();
        write_word(3'd3, 6'h17, 32'hFEED_001C);
        read_direct(6'd28, 32'hFEED_001C, "R4 vector 0x17 -> 28");
        write_word(3'd4, 6'h3E, 32'hBEEF_0020);
        read_direct(6'd32, 32'hBEEF_0020, "R4 matrix 0x3E -> 32");
        read_word(3'd4, 6'h02, "R4 matrix 2 -> 32");
        read_word(3'd3, 6'h07, "R4 vector 7 -> 28");
    endtask

    task automatic t_pair();
        write_pair(2'd0, 6'd10, 64'h1111_2222_3333_4444);
        read_direct(6'd10, 32'h1111_2222, "R5 high half to base");
        read_direct(6'd11, 32'h3333_4444, "R5 low half to base+1");
        write_word(3'd0, 6'd50, 32'hAAAA_0050);
        write_word(3'd0, 6'd51, 32'hBBBB_0051);
        dbl_rd_view = 2'd3; dbl_rd_idx = 6'd50; #1;
        check64("R5 pair read (code 3 direct)", dbl_rd_data, 64'hAAAA_0050_BBBB_0051);
    endtask

    task automatic t_pair_wrap();
        write_pair(2'd0, 6'd63, 64'hDEAD_003F_CAFE_0000);
        read_direct(6'd63, 32'hDEAD_003F, "R6 base 63 high");
        read_direct(6'd0, 32'hCAFE_0000, "R6 wraps to entry 0");
        dbl_rd_view = 2'd0; dbl_rd_idx = 6'd63; #1;
        check64("R6 pair read wraps", dbl_rd_data, 64'hDEAD_003F_CAFE_0000);
        write_fpc(32'h0020_0000);                          // bank bit via combined view
        check32("R8 bank from combined write", stat_rd_data, 32'h0000_4000);
        write_pair(2'd1, 6'd15, 64'h0000_001F_0000_0020);
        read_direct(6'd31, 32'h0000_001F, "R6 current bank1 idx15 -> 31");
        read_direct(6'd32, 32'h0000_0020, "R6 crosses into 32");
        write_pair(2'd2, 6'd15, 64'h0000_000F_0000_0010);
        read_direct(6'd15, 32'h0000_000F, "R6 opposite bank idx15 -> 15");
        read_direct(6'd16, 32'h0000_0010, "R6 opposite crosses into 16");
        dbl_rd_view = 2'd1; dbl_rd_idx = 6'd15; #1;
        check64("R6 banked pair read", dbl_rd_data, 64'h0000_001F_0000_0020);
    endtask

    task automatic t_ctrl();
        write_stat(32'h8000_3005);                          // prec=1 size=1 bank=0
        check32("R10 status whole word", stat_rd_data, 32'h8000_3005);
        check32("R7 combined read", fpc_rd_data, exp_fpc());
        check32("R7 combined value", fpc_rd_data, 32'h0018_0000 | m_fsw);
        write_fpc(32'h0025_00F1);                           // bits 21,18,16 -> bank=1 prec=0 size=0
        check32("R8 fsw stored whole", fsw_rd_data, 32'h0025_00F1);
        check32("R8 status bits copied", stat_rd_data, 32'h8000_4005);
        check32("R7 combined after write", fpc_rd_data, exp_fpc());
    endtask

    task automatic t_collide();
        sgl_wr_en = 1; sgl_wr_view = 3'd0; sgl_wr_idx = 6'd20; sgl_wr_data = 32'h5555_5555;
        dbl_wr_en = 1; dbl_wr_view = 2'd0; dbl_wr_idx = 6'd19; dbl_wr_data = 64'h0000_0013_0000_0014;
        commit();
        read_direct(6'd20, 32'h0000_0014, "R9 pair beats word");
        read_direct(6'd19, 32'h0000_0013, "R9 pair high");
        stat_wr_en = 1; stat_wr_data = 32'hFFFF_FFFF;
        fpc_wr_en = 1; fpc_wr_data = 32'h0010_0000;          // only size bit set
        commit();
        check32("R9 status split", stat_rd_data, 32'hFFFF_AFFF);
        check32("R9 fsw", fsw_rd_data, 32'h0010_0000);
        read_word(3'd1, 6'd4, "R9 bank now 0 after collision");
    endtask

    initial begin
        idle_inputs();
        sgl_rd_view = 0; sgl_rd_idx = 0; dbl_rd_view = 0; dbl_rd_idx = 0;
        for (int i = 0; i < 64; i++) m_mem[i] = 32'd0;
        m_st = 0; m_fsw = 0;
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_direct();
        t_bank();
        t_vecmtx();
        t_pair();
        t_pair_wrap();
        t_ctrl();
        t_collide();
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got hang expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule